// File: doc/BRIEF.md
# Attribute table-access mailbox responder

This block answers table-access requests that arrive over a dword-wide object mailbox. It serves entries from a small read-only table of coherent device attribute records. The host writes a request object one dword at a time and marks the final dword. The block checks the request and looks up the requested entry's start offset and byte size in a descriptor table. It then offers a response on the read side, one dword per read strobe.

Each response begins with a three-dword header. The first two dwords are the object header. The third dword is the table-access header. The entry's payload dwords follow, in order. The table-access header names the entry that follows the requested one, so the host can walk the whole table. It starts at entry 0 and keeps going until it receives the end-of-table handle. Malformed or out-of-range requests are dropped silently, with no response.

The table shape is set by parameters. The number of entries is `NUM_ENTRIES`. Entry i holds `LEN_BASE + LEN_STEP*i` bytes. The entries are packed back to back on dword boundaries. Payload dword at table word address `a` is `{8'hC3, a[7:0]^8'h5A, ~a[15:0]}`.

Top module: `cdat_mbox_responder`

## Requirements
- R1: After reset `rd_count` is 0. Whenever `rd_count` is 0, `rd_data` is 0.
- R2: A request is valid when it meets three conditions:
  - it has at least three dwords;
  - its length field (dword 1, bits [17:0]) is at least 3;
  - its handle (dword 2, bits [31:16]) is below `NUM_ENTRIES`.
  Two cycles after the final request dword is written, a valid request makes `rd_count` equal to 3 plus ceil(entry bytes / 4). The first response dword is 0x00021E98: vendor ID 0x1E98 in bits [15:0] and object type 0x02 in bits [23:16].
- R3: The second response dword carries the total response length in dwords in bits [17:0]. Its upper bits are zero.
- R4: The third response dword carries the response code 0 in bits [7:0] and the table type 0 in bits [15:8]. Bits [31:16] hold the next handle, which is the requested handle plus one.
- R5: For the last entry (handle `NUM_ENTRIES-1`), the next handle is 0xFFFF.
- R6: The payload dwords follow the header directly. They are the entry's dwords in order, starting at a dword base equal to the sum of the dword counts of all lower entries.
- R7: A request whose length field is below 3 produces no response; `rd_count` stays 0.
- R8: A request whose handle is `NUM_ENTRIES` or greater produces no response.
- R9: A request object that ends before its third dword produces no response.
- R10: Each read strobe while `rd_count` is nonzero removes exactly one dword and lowers `rd_count` by one. A read strobe while `rd_count` is 0 has no effect.
- R11: Request dwords written while a response is pending are ignored. The pending response is unchanged. A request sent after the mailbox drains is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Request dword present on `wr_data` |
| wr_data | input | 32 | Request dword |
| wr_last | input | 1 | Marks the final dword of a request object |
| rd_strobe | input | 1 | Removes the current response dword |
| rd_data | output | 32 | Current response dword, or 0 when empty |
| rd_count | output | 16 | Response dwords still waiting to be read |

## Verification
Every handle in the table is requested with a minimal three-dword object, and again with a longer object. Between them, these two passes separate a correct per-entry length, base and next-handle from an off-by-one in the descriptor or the end-of-table test. They also show that the handle is taken from the third dword and not from a later one. Short length fields, out-of-range handles and truncated objects are each swept separately, so each discard condition is seen to act on its own. Requests sent while a response is pending, and strobes sent while the mailbox is empty, show that the pending response and the counter stay intact.

// File: rtl/cdat_mbox_pkg.sv
package cdat_mbox_pkg;

    localparam logic [15:0] VENDOR_ID  = 16'h1E98;
    localparam logic [7:0]  OBJ_TYPE   = 8'h02;
    localparam logic [7:0]  RSP_CODE   = 8'h00;
    localparam logic [7:0]  TABLE_TYPE = 8'h00;
    localparam logic [15:0] END_HANDLE = 16'hFFFF;
    localparam int unsigned HDR_DW     = 3;
    localparam int unsigned REQ_DW     = 3;

    typedef struct packed {
        logic [15:0] base_dw;
        logic [15:0] len_dw;
    } desc_t;

    function automatic int unsigned ent_bytes(int unsigned i, int unsigned lb, int unsigned ls);
        return lb + ls * i;
    endfunction

    function automatic int unsigned ent_dw(int unsigned i, int unsigned lb, int unsigned ls);
        return (ent_bytes(i, lb, ls) + 3) / 4;
    endfunction

    function automatic int unsigned ent_base_dw(int unsigned i, int unsigned lb, int unsigned ls);
        int unsigned acc;
        acc = 0;
        for (int unsigned j = 0; j < i; j++) begin
            acc = acc + ent_dw(j, lb, ls);
        end
        return acc;
    endfunction

    function automatic logic [31:0] rom_word(logic [15:0] a);
        return {8'hC3, a[7:0] ^ 8'h5A, ~a};
    endfunction

endpackage

// File: rtl/cdat_req_parser.sv
module cdat_req_parser
    import cdat_mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        busy,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        wr_last,
    output logic        fire,
    output logic [15:0] fire_hnd
);

    localparam logic [15:0] N16     = 16'(NUM_ENTRIES);
    localparam logic [17:0] MIN_LEN = 18'(REQ_DW);

    typedef struct packed {
        logic [1:0]  cnt;
        logic [17:0] len;
        logic [15:0] hnd;
        logic        fire;
        logic [15:0] fire_hnd;
    } state_t;

    state_t st_d, st_q;
    logic [15:0] cur_hnd;
    logic        unused_ok;

    assign unused_ok = ^{wr_data[15:0]};

    always_comb begin
        st_d      = st_q;
        st_d.fire = 1'b0;
        cur_hnd   = (st_q.cnt == 2'd2) ? wr_data[31:16] : st_q.hnd;
        if (wr_valid && !busy) begin
            if (st_q.cnt == 2'd1) st_d.len = wr_data[17:0];
            if (st_q.cnt == 2'd2) st_d.hnd = wr_data[31:16];
            if (wr_last) begin
                st_d.cnt = 2'd0;
                if (st_q.cnt >= 2'd2 && st_q.len >= MIN_LEN && cur_hnd < N16) begin
                    st_d.fire     = 1'b1;
                    st_d.fire_hnd = cur_hnd;
                end
            end else if (st_q.cnt != 2'd3) begin
                st_d.cnt = st_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign fire     = st_q.fire;
    assign fire_hnd = st_q.fire_hnd;

endmodule

// File: rtl/cdat_entry_table.sv
module cdat_entry_table
    import cdat_mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    parameter int unsigned LEN_BASE    = 6,
    parameter int unsigned LEN_STEP    = 5
) (
    input  logic [15:0] handle,
    input  logic [15:0] word_idx,
    output logic [15:0] len_dw,
    output logic [31:0] data
);

    localparam int unsigned IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [15:0] N16   = 16'(NUM_ENTRIES);

    desc_t desc [NUM_ENTRIES];
    desc_t sel;

    for (genvar i = 0; i < int'(NUM_ENTRIES); i++) begin : g_desc
        assign desc[i].base_dw = 16'(ent_base_dw(i, LEN_BASE, LEN_STEP));
        assign desc[i].len_dw  = 16'(ent_dw(i, LEN_BASE, LEN_STEP));
    end

    always_comb begin
        sel = '0;
        if (handle < N16) sel = desc[handle[IDX_W-1:0]];
    end

    assign len_dw = sel.len_dw;
    assign data   = rom_word(sel.base_dw + word_idx);

endmodule

// File: rtl/cdat_rsp_gen.sv
module cdat_rsp_gen
    import cdat_mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fire,
    input  logic [15:0] fire_hnd,
    input  logic        rd_strobe,
    input  logic [15:0] len_dw,
    input  logic [31:0] ent_data,
    output logic [15:0] tbl_hnd,
    output logic [15:0] word_idx,
    output logic        busy,
    output logic [31:0] rd_data,
    output logic [15:0] rd_count
);

    localparam logic [15:0] LAST_H = 16'(NUM_ENTRIES - 1);
    localparam logic [15:0] HDR16  = 16'(HDR_DW);

    typedef struct packed {
        logic [15:0] count;
        logic [15:0] idx;
        logic [15:0] hnd;
    } state_t;

    state_t st_d, st_q;
    logic [15:0] total;
    logic [15:0] next_hnd;

    assign tbl_hnd  = fire ? fire_hnd : st_q.hnd;
    assign total    = HDR16 + len_dw;
    assign word_idx = st_q.idx - HDR16;
    assign next_hnd = (st_q.hnd == LAST_H) ? END_HANDLE : st_q.hnd + 16'd1;
    assign busy     = fire || (st_q.count != 16'd0);

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.count = st_q.count + total;
            st_d.idx   = 16'd0;
            st_d.hnd   = fire_hnd;
        end else if (rd_strobe && st_q.count != 16'd0) begin
            st_d.count = st_q.count - 16'd1;
            st_d.idx   = st_q.idx + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (st_q.count == 16'd0)  rd_data = 32'd0;
        else if (st_q.idx == 16'd0) rd_data = {8'h00, OBJ_TYPE, VENDOR_ID};
        else if (st_q.idx == 16'd1) rd_data = {16'd0, total};
        else if (st_q.idx == 16'd2) rd_data = {next_hnd, TABLE_TYPE, RSP_CODE};
        else                        rd_data = ent_data;
    end

    assign rd_count = st_q.count;

endmodule

// File: rtl/cdat_mbox_responder.sv
module cdat_mbox_responder
    import cdat_mbox_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = 4,
    parameter int unsigned LEN_BASE    = 6,
    parameter int unsigned LEN_STEP    = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_valid,
    input  logic [31:0] wr_data,
    input  logic        wr_last,
    input  logic        rd_strobe,
    output logic [31:0] rd_data,
    output logic [15:0] rd_count
);

    logic        fire;
    logic [15:0] fire_hnd;
    logic        busy;
    logic [15:0] tbl_hnd;
    logic [15:0] word_idx;
    logic [15:0] len_dw;
    logic [31:0] ent_data;

    cdat_req_parser #(.NUM_ENTRIES(NUM_ENTRIES)) u_parser (
        .clk(clk), .rst_n(rst_n), .busy(busy),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .fire(fire), .fire_hnd(fire_hnd)
    );

    cdat_entry_table #(
        .NUM_ENTRIES(NUM_ENTRIES), .LEN_BASE(LEN_BASE), .LEN_STEP(LEN_STEP)
    ) u_table (
        .handle(tbl_hnd), .word_idx(word_idx), .len_dw(len_dw), .data(ent_data)
    );

    cdat_rsp_gen #(.NUM_ENTRIES(NUM_ENTRIES)) u_rsp (
        .clk(clk), .rst_n(rst_n), .fire(fire), .fire_hnd(fire_hnd),
        .rd_strobe(rd_strobe), .len_dw(len_dw), .ent_data(ent_data),
        .tbl_hnd(tbl_hnd), .word_idx(word_idx), .busy(busy),
        .rd_data(rd_data), .rd_count(rd_count)
    );

endmodule

// File: rtl/cdat_mbox_checker.sv
module cdat_mbox_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rd_strobe,
    input logic [31:0] rd_data,
    input logic [15:0] rd_count
);

    a_r10_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && rd_count != 16'd0) |=> (rd_count == $past(rd_count) - 16'd1));

    a_r11_hold_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe && rd_count != 16'd0) |=> (rd_count == $past(rd_count)));

    a_r1_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_count == 16'd0) |-> (rd_data == 32'd0));

    a_r2_header_first: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_count) == 16'd0 && rd_count != 16'd0) |-> (rd_data == 32'h0002_1E98));

    a_r2_min_length: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_count) == 16'd0 && rd_count != 16'd0) |-> (rd_count >= 16'd3));

endmodule

bind cdat_mbox_responder cdat_mbox_checker u_checker (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe),
    .rd_data(rd_data), .rd_count(rd_count)
);

// File: tb/cdat_mbox_responder_tb.sv
module cdat_mbox_responder_tb;

    localparam int N  = 4;
    localparam int LB = 6;
    localparam int LS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_last = 1'b0;
    logic        rd_strobe = 1'b0;
    logic [31:0] rd_data;
    logic [15:0] rd_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    cdat_mbox_responder #(.NUM_ENTRIES(N), .LEN_BASE(LB), .LEN_STEP(LS)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .rd_strobe(rd_strobe), .rd_data(rd_data), .rd_count(rd_count)
    );

    function automatic int e_dw(int h);
        return (LB + LS * h + 3) / 4;
    endfunction

    function automatic int e_base(int h);
        int b = 0;
        for (int j = 0; j < h; j++) b += e_dw(j);
        return b;
    endfunction

    function automatic logic [31:0] e_word(int a);
        logic [15:0] w = 16'(a);
        return {8'hC3, w[7:0] ^ 8'h5A, ~w};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_req(int ndw, int lenf, int hnd);
        for (int k = 0; k < ndw; k++) begin
            @(negedge clk);
            wr_valid = 1'b1;
            wr_last  = (k == ndw - 1);
            if (k == 0)      wr_data = 32'h0002_1E98;
            else if (k == 1) wr_data = 32'(lenf);
            else if (k == 2) wr_data = {16'(hnd), 16'h0000};
            else             wr_data = {16'(N - 1 - (k % N)), 16'h0};
        end
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_rsp(int h);
        int total = 3 + e_dw(h);
        logic [15:0] nh = (h == N - 1) ? 16'hFFFF : 16'(h + 1);
        chk("R2 count", 32'(rd_count), 32'(total));
        for (int k = 0; k < total; k++) begin
            chk("R10 count step", 32'(rd_count), 32'(total - k));
            if (k == 0)      chk("R2 dword0", rd_data, 32'h0002_1E98);
            else if (k == 1) chk("R3 length", rd_data, 32'(total));
            else if (k == 2) chk((h == N - 1) ? "R5 end handle" : "R4 table hdr", rd_data, {nh, 16'h0000});
            else             chk("R6 payload", rd_data, e_word(e_base(h) + k - 3));
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
        end
        chk("R10 drained", 32'(rd_count), 0);
        chk("R1 empty data", rd_data, 0);
    endtask

    task automatic expect_none(string tag);
        repeat (2) @(negedge clk);
        chk(tag, 32'(rd_count), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset count", 32'(rd_count), 0);
        chk("R1 reset data", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int h = 0; h < N; h++) begin
            send_req(3, 3, h);
            read_rsp(h);
            send_req(5, 5, h);
            read_rsp(h);
        end
        for (int h = 0; h < N; h++) begin
            for (int l = 0; l < 3; l++) begin
                send_req(3, l, h);
                expect_none("R7 short length");
            end
        end
        for (int h = N; h < N + 3; h++) begin
            send_req(3, 3, h);
            expect_none("R8 handle range");
        end
        send_req(1, 3, 0);
        expect_none("R9 truncated");
        send_req(2, 3, 0);
        expect_none("R9 truncated");
        send_req(3, 3, 0);
        read_rsp(0);

        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        chk("R10 empty strobe", 32'(rd_count), 0);
        chk("R10 empty data", rd_data, 0);

        send_req(3, 3, 1);
        send_req(3, 3, 3);
        read_rsp(1);
        expect_none("R11 ignored while pending");
        send_req(3, 3, 2);
        read_rsp(2);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule